// File: doc/BRIEF.md
# Bus Hold Arbiter with Refresh Timer

This block decides who may take a processor's local bus away from it. Two parties can need the bus. The first is a DRAM refresh path. The second is a host that reaches into local memory from a slower, unrelated clock domain. The block asks for the bus by raising `hold`. It waits for the processor to answer on `hlda`. It then hands the bus to exactly one party through a one-hot pair of grants. When that party is finished, the block drops `hold` again.

The block also keeps a refresh interval timer. The DRAM controller can often slip a refresh into a cycle in which the RAM is idle. It reports each such hidden refresh by toggling `hidden_ref_tgl`, and each report restarts the timer, so no bus request is needed. If the whole interval passes with no hidden refresh, the block forces a refresh. It raises `hold` and grants the bus to the refresh path for a fixed, short number of cycles, two T-states by default.

The host request and the hidden-refresh toggle both cross clock domains, and each passes through a two-flop synchronizer. `hlda` and `host_done` are taken to be synchronous to `clk`.

Top module: `hold_arb_top`

## Requirements
- R1: While `rst_n` is low, `hold`, `gnt_host` and `gnt_ref` are all 0.
- R2: At most one of `gnt_host` and `gnt_ref` is 1 in any cycle.
- R3: A grant appears only while `hold` is 1. It appears one cycle after `hlda` is sampled high. While `hlda` stays low, no grant is given and `hold` stays 1.
- R4: With no host traffic and no hidden refresh, `hold` rises again exactly `REFRESH_INTERVAL`+1 cycles after the last cycle in which `gnt_ref` was high, given that `hlda` follows `hold`.
- R5: A change of level on `hidden_ref_tgl` restarts the interval and cancels a refresh that is pending but not yet requested. The next forced `hold` rises `REFRESH_INTERVAL`+4 cycles after the toggle: two synchronizer stages, one edge-detect stage, then the R4 interval.
- R6: When a forced refresh is pending and a host request is also waiting in the idle state, the refresh is granted first.
- R7: Once `gnt_host` is 1, it stays 1 until `host_done` is sampled high. A pending refresh never cuts a host cycle short.
- R8: A forced refresh holds `gnt_ref` high for exactly `REF_TSTATES` consecutive cycles. `hold` is 0 in the cycle that follows.
- R9: When `host_done` is sampled high while `gnt_host` is 1, `hold` and `gnt_host` are 0 in the next cycle.
- R10: A host request raised while the arbiter is idle, with no refresh pending, drives `hold` high on the third rising clock edge after the request changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host bus request, asynchronous level |
| host_done | input | 1 | Host ends its bus cycle; one-cycle pulse while it holds the grant |
| hidden_ref_tgl | input | 1 | Changes level once for each hidden refresh; asynchronous |
| hlda | input | 1 | Hold acknowledge from the processor |
| hold | output | 1 | Hold request to the processor |
| gnt_host | output | 1 | Bus granted to the host |
| gnt_ref | output | 1 | Bus granted to the refresh path (forced refresh) |

## Verification
The assertions take the following for granted about the block's inputs:
- `hlda` is synchronous to `clk`.
- `hlda` never rises unless `hold` is high, and it stays high for as long as a grant is out.
- `host_done` is a single-cycle pulse, given only while the host holds the bus.

The bench meets these rules by driving `hlda` from `hold`, updated once per cycle on the falling edge, and by letting the host driver pulse `host_done` only after it has seen `gnt_host`. Random host cycle lengths, idle gaps and hidden-refresh toggles stay inside these rules. A directed phase holds `hlda` low on purpose to show that a grant waits for the acknowledge.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQ_REF   = 3'd1,
    ST_REQ_HOST  = 3'd2,
    ST_OWN_REF   = 3'd3,
    ST_OWN_HOST  = 3'd4,
    ST_RELEASE   = 3'd5
  } arb_state_t;

  // hold is asserted while requesting or owning the bus
  function automatic logic state_holds(input arb_state_t s);
    return (s == ST_REQ_REF) || (s == ST_REQ_HOST) ||
           (s == ST_OWN_REF) || (s == ST_OWN_HOST);
  endfunction

endpackage

// File: rtl/hold_arb_sync.sv
module hold_arb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hold_arb_refresh_timer.sv
module hold_arb_refresh_timer #(
  parameter int INTERVAL = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hidden_evt,
  input  logic refresh_done,
  output logic ref_pend
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] advance(input logic [CW-1:0] c);
    return (c == LAST) ? c : c + 1'b1;
  endfunction

  function automatic logic expiring(input logic [CW-1:0] c);
    return c == LAST;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ref_pend <= 1'b0;
    end else if (hidden_evt || refresh_done) begin
      cnt      <= '0;
      ref_pend <= 1'b0;
    end else begin
      cnt <= advance(cnt);
      if (expiring(cnt)) ref_pend <= 1'b1;
    end
  end

  AST_HIDDEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_evt |=> !ref_pend); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !hidden_evt && !refresh_done) |=> ref_pend); // R4

endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
  import hold_arb_pkg::*;
#(
  parameter int REF_TS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req_s,
  input  logic ref_pend,
  input  logic hlda,
  input  logic host_done,
  output logic hold,
  output logic gnt_host,
  output logic gnt_ref,
  output logic ref_done
);
  localparam int TW = $clog2(REF_TS + 1);
  localparam logic [TW-1:0] TS_LAST = TW'(REF_TS - 1);

  arb_state_t state, nxt;
  logic [TW-1:0] ts_cnt;

  assign ref_done = (state == ST_OWN_REF) && (ts_cnt == TS_LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (ref_pend) nxt = ST_REQ_REF;
                   else if (host_req_s) nxt = ST_REQ_HOST;
      ST_REQ_REF:  if (hlda) nxt = ST_OWN_REF;
      ST_REQ_HOST: if (hlda) nxt = ST_OWN_HOST;
      ST_OWN_REF:  if (ref_done) nxt = ST_RELEASE;
      ST_OWN_HOST: if (host_done) nxt = ST_RELEASE;
      ST_RELEASE:  if (!hlda) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ts_cnt <= '0;
    end else begin
      state  <= nxt;
      ts_cnt <= (state == ST_OWN_REF) ? ts_cnt + 1'b1 : '0;
    end
  end

  assign hold     = state_holds(state);
  assign gnt_host = (state == ST_OWN_HOST);
  assign gnt_ref  = (state == ST_OWN_REF);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_host, gnt_ref})); // R2
  AST_GNT_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_host || gnt_ref) |-> (hold && hlda)); // R3
  AST_REF_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_ref) |-> $past(hlda)); // R3
  AST_HOST_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_host) |-> $past(hlda)); // R3
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_host && !host_done) |=> gnt_host); // R7
  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_host && host_done) |=> !hold); // R9
  AST_REF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_ref) |-> !hold); // R8

  generate
    if (REF_TS >= 2) begin : g_multi_ts
      AST_REF_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_ref) |=> gnt_ref); // R8
    end
  endgenerate

endmodule

// File: rtl/hold_arb_top.sv
module hold_arb_top #(
  parameter int REFRESH_INTERVAL = 3000,
  parameter int REF_TSTATES      = 2,
  parameter int SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic host_done,
  input  logic hidden_ref_tgl,
  input  logic hlda,
  output logic hold,
  output logic gnt_host,
  output logic gnt_ref
);
  logic [1:0] sync_q;
  logic       host_req_s;
  logic       hidden_s;
  logic       hidden_prev;
  logic       hidden_evt;
  logic       ref_pend;
  logic       ref_done;

  hold_arb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({hidden_ref_tgl, host_req}),
    .q     (sync_q)
  );

  assign host_req_s = sync_q[0];
  assign hidden_s   = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) hidden_prev <= 1'b0;
    else        hidden_prev <= hidden_s;
  end

  assign hidden_evt = hidden_s ^ hidden_prev;

  hold_arb_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .hidden_evt   (hidden_evt),
    .refresh_done (ref_done),
    .ref_pend     (ref_pend)
  );

  hold_arb_fsm #(.REF_TS(REF_TSTATES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req_s (host_req_s),
    .ref_pend   (ref_pend),
    .hlda       (hlda),
    .host_done  (host_done),
    .hold       (hold),
    .gnt_host   (gnt_host),
    .gnt_ref    (gnt_ref),
    .ref_done   (ref_done)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!hold && !gnt_host && !gnt_ref)); // R1

endmodule

// File: tb/hold_arb_top_tb.sv
module hold_arb_top_tb;
  localparam int INTERVAL = 40;
  localparam int REF_TS   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0;
  logic host_done = 1'b0;
  logic hidden_ref_tgl = 1'b0;
  logic hlda = 1'b0;
  logic hlda_block = 1'b0;
  logic hold, gnt_host, gnt_ref;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ref_run = 0;

  always #2 clk = ~clk;

  hold_arb_top #(.REFRESH_INTERVAL(INTERVAL), .REF_TSTATES(REF_TS)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_done(host_done),
    .hidden_ref_tgl(hidden_ref_tgl), .hlda(hlda), .hold(hold),
    .gnt_host(gnt_host), .gnt_ref(gnt_ref)
  );

  function automatic int exp_host_latency();  return 3;            endfunction
  function automatic int exp_refresh_gap();   return INTERVAL + 1; endfunction
  function automatic int exp_hidden_gap();    return INTERVAL + 4; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // processor model: acknowledge follows hold once per cycle
  always @(negedge clk) hlda <= hold && !hlda_block;

  // per-cycle monitor
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(gnt_host && gnt_ref), "R2", {gnt_host, gnt_ref}, 1);
      if (gnt_host || gnt_ref) chk(hold && hlda, "R3", {hold, hlda}, 3);
      if (gnt_ref) ref_run++;
      else if (ref_run != 0) begin
        chk(ref_run == REF_TS, "R8", ref_run, REF_TS);
        ref_run = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic count_to_hold(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!hold && k < 1000);
  endtask

  task automatic wait_ref_end();
    do @(negedge clk); while (!gnt_ref);
    while (gnt_ref) @(negedge clk);
    chk(!hold, "R8", hold, 0);
  endtask

  task automatic wait_host_grant();
    int k = 0;
    while (!gnt_host && k < 500) begin @(negedge clk); k++; end
    chk(gnt_host, "R3", gnt_host, 1);
  endtask

  task automatic host_finish(input int len, input bit keep_req);
    repeat (len) begin
      chk(gnt_host, "R7", gnt_host, 1);
      @(negedge clk);
    end
    host_done = 1'b1;
    host_req  = keep_req;
    @(negedge clk);
    host_done = 1'b0;
    chk(!hold && !gnt_host, "R9", {hold, gnt_host}, 0);
  endtask

  initial begin
    int k;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    chk(!hold && !gnt_host && !gnt_ref, "R1", {hold, gnt_host, gnt_ref}, 0);
    rst_n = 1'b1;

    // R10: synchronizer latency on host request
    host_req = 1'b1;
    count_to_hold(k);
    chk(k == exp_host_latency(), "R10", k, exp_host_latency());
    @(negedge clk);
    chk(gnt_host, "R3", gnt_host, 1);
    host_finish(5, 1'b0);

    // R4: forced refresh period
    wait_ref_end();
    count_to_hold(k);
    chk(k == exp_refresh_gap(), "R4", k, exp_refresh_gap());

    // R5: hidden refresh restarts the interval
    wait_ref_end();
    hidden_ref_tgl = ~hidden_ref_tgl;
    count_to_hold(k);
    chk(k == exp_hidden_gap(), "R5", k, exp_hidden_gap());

    // R3: no grant while the acknowledge is withheld
    wait_ref_end();
    hlda_block = 1'b1;
    host_req   = 1'b1;
    repeat (10) @(negedge clk);
    chk(hold && !gnt_host && !gnt_ref, "R3", {hold, gnt_host, gnt_ref}, 4);
    hlda_block = 1'b0;
    wait_host_grant();
    host_finish(2, 1'b0);

    // R7 then R6: long host cycle spans the interval, refresh goes next
    wait_ref_end();
    host_req = 1'b1;
    wait_host_grant();
    host_finish(INTERVAL + 10, 1'b1);
    k = 0;
    while (!gnt_ref && !gnt_host && k < 200) begin @(negedge clk); k++; end
    chk(gnt_ref && !gnt_host, "R6", {gnt_host, gnt_ref}, 1);
    wait_host_grant();
    host_finish(3, 1'b0);

    // random host traffic with hidden refresh toggles
    for (int it = 0; it < 40; it++) begin
      int gap = $urandom_range(0, 20);
      repeat (gap) begin
        @(negedge clk);
        if ($urandom_range(0, 9) == 0) hidden_ref_tgl = ~hidden_ref_tgl;
      end
      host_req = 1'b1;
      wait_host_grant();
      host_finish($urandom_range(1, 8), 1'b0);
    end

    repeat (3 * INTERVAL) @(negedge clk);
    summary();
    $finish;
  end

endmodule